// File: doc/BRIEF.md
# Byte-Splittable General Register File

This block is a file of eight 16-bit general registers reached through one index and one access slot per cycle. A cycle carries either a single read or a single write of the selected register, never both. Every read returns the whole 16-bit word. A consumer that wants only one byte simply ignores the other half.

The four lowest registers (index 0 to 3) can also take a write to their low byte or their high byte alone. The other half is left untouched, so a byte update completes in one access instead of a read, a merge and a write-back. Registers 4 to 7 take whole-word writes only. A byte-mode request aimed at them is refused and flagged.

Inside the file, each stored word keeps its two byte halves bit-interleaved. Low-byte bit k sits at lane 2k and high-byte bit k sits at lane 2k+1. Because of this, the half-swap path only exchanges neighbouring lanes. The swap control exchanges the halves on the way in (for writes) and on the way out (for reads). Data at the ports always appears in normal bit order.

Top module: `gp_regfile`

## Requirements
- R1: After synchronous reset every register reads as 0x0000, and both `rd_data_o` and `illegal_o` are 0.
- R2: A word write (`mode_i`=0, `swap_i`=0) to any index stores `wdata_i` unchanged. A read with `rd_en_i`=1 and `swap_i`=0 presents that word on `rd_data_o` one cycle after the request, in normal bit order.
- R3: A low-byte write (`mode_i`=1) to index 0..3 replaces bits [7:0] of the register and leaves bits [15:8] unchanged.
- R4: A high-byte write (`mode_i`=2) to index 0..3 replaces bits [15:8] of the register and leaves bits [7:0] unchanged.
- R5: A byte write (`mode_i`=1 or 2) to index 4..7 leaves the register unchanged, and `illegal_o` is 1 in the following cycle.
- R6: A cycle with both `rd_en_i` and `wr_en_i` set performs neither access. The register and `rd_data_o` stay unchanged, and `illegal_o` is 1 in the following cycle.
- R7: A read with `swap_i`=1 presents the stored word with its halves exchanged: {word[7:0], word[15:8]}.
- R8: A write with `swap_i`=1 first exchanges the halves of `wdata_i`. A word write stores {wdata[7:0], wdata[15:8]}. A low-byte write takes wdata[15:8] into bits [7:0]. A high-byte write takes wdata[7:0] into bits [15:8].
- R9: `mode_i`=3 is reserved. A write with it changes no register at any index, and `illegal_o` is 1 in the following cycle.
- R10: `rd_data_o` changes only in the cycle after an accepted read and otherwise holds its value. `illegal_o` is 0 in the cycle after any accepted access or idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_i | input | 3 | Register index |
| rd_en_i | input | 1 | Read request |
| wr_en_i | input | 1 | Write request |
| mode_i | input | 2 | Write width: 0 word, 1 low byte, 2 high byte, 3 reserved |
| swap_i | input | 1 | Exchange byte halves on this access |
| wdata_i | input | 16 | Write data, normal bit order |
| rd_data_o | output | 16 | Registered read data, normal bit order |
| illegal_o | output | 1 | Previous cycle's request was refused |

## Verification
On every cycle the assertions check several things. A register with no strobe holds its value. A single-half strobe leaves the opposite lanes of a split register alone. Registers 4 to 7 never see a lone half strobe. Read data holds between reads. Conflicting or reserved requests raise the flag. Only the bench scenarios can show the arithmetic content of the results. These cover the interleave and de-interleave giving normal bit order, the exact swapped values in both directions, and which byte of the bus lands where. The bench sweeps every index, mode and swap setting for this.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

    localparam int DW = 16;
    localparam int HW = DW / 2;

    typedef enum logic [1:0] {
        ACC_WORD = 2'd0,
        ACC_LOW  = 2'd1,
        ACC_HIGH = 2'd2,
        ACC_RSVD = 2'd3
    } acc_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } strobe_t;

    // normal word -> interleaved lanes (low bit k at 2k, high bit k at 2k+1)
    function automatic logic [DW-1:0] to_lanes(input logic [DW-1:0] w);
        logic [DW-1:0] r;
        for (int k = 0; k < HW; k++) begin
            r[2*k]   = w[k];
            r[2*k+1] = w[k+HW];
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] from_lanes(input logic [DW-1:0] s);
        logic [DW-1:0] r;
        for (int k = 0; k < HW; k++) begin
            r[k]    = s[2*k];
            r[k+HW] = s[2*k+1];
        end
        return r;
    endfunction

    // half exchange in lane order: neighbouring lanes trade places
    function automatic logic [DW-1:0] pair_swap(input logic [DW-1:0] s);
        logic [DW-1:0] r;
        for (int k = 0; k < HW; k++) begin
            r[2*k]   = s[2*k+1];
            r[2*k+1] = s[2*k];
        end
        return r;
    endfunction

endpackage

// File: rtl/rf_decode.sv
module rf_decode
    import gprf_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int NSPLIT = 4,
    localparam int IDXW  = $clog2(NREG)
) (
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [IDXW-1:0]      idx,
    input  acc_e                 mode,
    output strobe_t [NREG-1:0]   stb,
    output logic                 rd_go,
    output logic                 refuse
);
    localparam logic [IDXW:0] SPLIT_LIM = (IDXW+1)'(NSPLIT);

    logic byte_ok;
    logic write_go;

    always_comb begin
        byte_ok  = ({1'b0, idx} < SPLIT_LIM);
        write_go = wr_en && !rd_en &&
                   ((mode == ACC_WORD) ||
                    (((mode == ACC_LOW) || (mode == ACC_HIGH)) && byte_ok));
        rd_go    = rd_en && !wr_en;
        refuse   = wr_en && !write_go;
        for (int i = 0; i < NREG; i++) begin
            stb[i].lo = write_go && (idx == IDXW'(i)) && (mode != ACC_HIGH);
            stb[i].hi = write_go && (idx == IDXW'(i)) && (mode != ACC_LOW);
        end
    end

endmodule

// File: rtl/rf_bank.sv
module rf_bank
    import gprf_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int NSPLIT = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  strobe_t [NREG-1:0]          stb,
    input  logic    [DW-1:0]            wlanes,
    output logic    [NREG-1:0][DW-1:0]  q
);
    localparam logic [DW-1:0] ODD_LANES  = {HW{2'b10}};
    localparam logic [DW-1:0] EVEN_LANES = {HW{2'b01}};

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i < NSPLIT) begin : g_split
            logic [DW-1:0] mask;
            assign mask = {HW{stb[i].hi, stb[i].lo}};
            always_ff @(posedge clk) begin
                if (rst) q[i] <= '0;
                else     q[i] <= (q[i] & ~mask) | (wlanes & mask);
            end

            a_r3_low_keeps_high: assert property (@(posedge clk) disable iff (rst)
                (stb[i].lo && !stb[i].hi) |=>
                    ((q[i] & ODD_LANES) == ($past(q[i]) & ODD_LANES)));
            a_r4_high_keeps_low: assert property (@(posedge clk) disable iff (rst)
                (stb[i].hi && !stb[i].lo) |=>
                    ((q[i] & EVEN_LANES) == ($past(q[i]) & EVEN_LANES)));
        end else begin : g_full
            always_ff @(posedge clk) begin
                if (rst)                      q[i] <= '0;
                else if (stb[i].lo || stb[i].hi) q[i] <= wlanes;
            end

            a_r5_word_only: assert property (@(posedge clk) disable iff (rst)
                stb[i].lo == stb[i].hi);
        end

        a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
            !(stb[i].lo || stb[i].hi) |=> $stable(q[i]));
    end

    a_r6_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb[0].lo, stb[1].lo, stb[2].lo, stb[3].lo,
                  stb[NREG-4].hi, stb[NREG-3].hi, stb[NREG-2].hi, stb[NREG-1].hi}) ||
        (NREG != 8));

endmodule

// File: rtl/rf_readout.sv
module rf_readout
    import gprf_pkg::*;
#(
    parameter int NREG  = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_go,
    input  logic                        swap,
    input  logic [IDXW-1:0]             idx,
    input  logic [NREG-1:0][DW-1:0]     q,
    output logic [DW-1:0]               rdata
);
    logic [DW-1:0] picked;

    always_comb begin
        picked = q[idx];
        if (swap) picked = pair_swap(picked);
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_go) rdata <= from_lanes(picked);
    end

    a_r10_read_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(rdata));

endmodule

// File: rtl/gp_regfile.sv
module gp_regfile
    import gprf_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int NSPLIT = 4,
    localparam int IDXW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] idx_i,
    input  logic            rd_en_i,
    input  logic            wr_en_i,
    input  logic [1:0]      mode_i,
    input  logic            swap_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rd_data_o,
    output logic            illegal_o
);
    strobe_t [NREG-1:0]         stb;
    logic                       rd_go;
    logic                       refuse;
    logic [DW-1:0]              wlanes;
    logic [NREG-1:0][DW-1:0]    q;

    always_comb begin
        wlanes = to_lanes(wdata_i);
        if (swap_i) wlanes = pair_swap(wlanes);
    end

    rf_decode #(.NREG(NREG), .NSPLIT(NSPLIT)) u_dec (
        .rd_en  (rd_en_i),
        .wr_en  (wr_en_i),
        .idx    (idx_i),
        .mode   (acc_e'(mode_i)),
        .stb    (stb),
        .rd_go  (rd_go),
        .refuse (refuse)
    );

    rf_bank #(.NREG(NREG), .NSPLIT(NSPLIT)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .wlanes (wlanes),
        .q      (q)
    );

    rf_readout #(.NREG(NREG)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_go (rd_go),
        .swap  (swap_i),
        .idx   (idx_i),
        .q     (q),
        .rdata (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) illegal_o <= 1'b0;
        else     illegal_o <= refuse;
    end

    a_r6_conflict_flag: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && wr_en_i) |=> illegal_o);
    a_r9_reserved_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && mode_i == 2'd3) |=> illegal_o);
    a_r10_read_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !wr_en_i) |=> !illegal_o);

endmodule

// File: tb/sim_gp_regfile.sv
module sim_gp_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  idx_i = '0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic        swap_i = 1'b0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rd_data_o;
    logic        illegal_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] model [8];

    always #2 clk = ~clk;

    gp_regfile u0 (
        .clk(clk), .rst(rst), .idx_i(idx_i), .rd_en_i(rd_en_i),
        .wr_en_i(wr_en_i), .mode_i(mode_i), .swap_i(swap_i),
        .wdata_i(wdata_i), .rd_data_o(rd_data_o), .illegal_o(illegal_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] hswap(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic do_read(input int i, input bit s, input string tag);
        logic [15:0] e;
        @(negedge clk);
        idx_i = 3'(i); rd_en_i = 1'b1; wr_en_i = 1'b0; swap_i = s; mode_i = 2'd0;
        @(posedge clk); #1;
        e = s ? hswap(model[i]) : model[i];
        chk(tag, rd_data_o, e);
        chk("R10", {15'd0, illegal_o}, 16'd0);
    endtask

    task automatic do_write(input int i, input int m, input bit s,
                            input logic [15:0] d, input string tag);
        logic [15:0] sw;
        bit ref_flag;
        sw = s ? hswap(d) : d;
        ref_flag = 1'b0;
        if (m == 0)                model[i] = sw;
        else if (m == 3)           ref_flag = 1'b1;
        else if (i >= 4)           ref_flag = 1'b1;
        else if (m == 1)           model[i][7:0]  = sw[7:0];
        else                       model[i][15:8] = sw[15:8];
        @(negedge clk);
        idx_i = 3'(i); rd_en_i = 1'b0; wr_en_i = 1'b1; swap_i = s;
        mode_i = 2'(m); wdata_i = d;
        @(posedge clk); #1;
        chk(tag, {15'd0, illegal_o}, {15'd0, ref_flag});
    endtask

    task automatic idle;
        @(negedge clk);
        rd_en_i = 1'b0; wr_en_i = 1'b0;
    endtask

    initial begin
        logic [15:0] hold;
        for (int i = 0; i < 8; i++) model[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1", rd_data_o, 16'h0000);
        chk("R1", {15'd0, illegal_o}, 16'd0);
        for (int i = 0; i < 8; i++) do_read(i, 1'b0, "R1");

        // sweep every index, mode and swap setting
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [15:0] d;
                    string t;
                    d = 16'hA5C3 ^ 16'(i * 16'h1357) ^ 16'(m * 16'h0F0F) ^ 16'(s * 16'h8421);
                    if (m == 3)              t = "R9";
                    else if (i >= 4 && m != 0) t = "R5";
                    else if (s == 1)         t = "R8";
                    else if (m == 0)         t = "R2";
                    else if (m == 1)         t = "R3";
                    else                     t = "R4";
                    do_write(i, m, 1'(s), d, t);
                    do_read(i, 1'b0, t);
                    do_read(i, 1'b1, "R7");
                end
            end
        end

        // read data holds across idle and write cycles
        do_read(1, 1'b0, "R2");
        hold = model[1];
        idle;
        @(posedge clk); #1;
        chk("R10", rd_data_o, hold);
        do_write(5, 0, 1'b0, 16'h3C5A, "R2");
        chk("R10", rd_data_o, hold);
        do_read(5, 1'b0, "R2");

        // simultaneous read and write: neither happens
        hold = rd_data_o;
        @(negedge clk);
        idx_i = 3'd2; rd_en_i = 1'b1; wr_en_i = 1'b1; mode_i = 2'd0;
        swap_i = 1'b0; wdata_i = ~model[2];
        @(posedge clk); #1;
        chk("R6", {15'd0, illegal_o}, 16'd1);
        chk("R6", rd_data_o, hold);
        do_read(2, 1'b0, "R6");

        idle;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule